// File: doc/BRIEF.md
# Bidirectional GPIO Port with Analog Select

This block is an 8-bit parallel I/O port that sits on a simple processor register bus. It holds three registers. An output latch sets the level each pin drives. A direction register decides per pin whether the output buffer drives or floats. An analog-select register marks pins that are handed to an analog function. The pad is modelled as three separate vectors: a drive value, an output enable, and a sampled input level.

Software reaches the port through a 2-bit register address with write and read enables. Reading the latch address returns what software wrote, so a read-modify-write of the latch keeps the values of pins that are currently inputs. Reading the pin address returns the synchronized pad levels. Pins selected as analog read as zero on that path.

Only a fixed subset of pins can be analog. Those pins start up in analog mode, and every pin starts as an input.

Top module: `gpio_port`

## Requirements
- R1: A synchronous active-high reset sets the latch to 0x00 and every direction bit to 1, so `pad_oe` = 0x00. It sets the analog-select register to 0x2F, which marks pins 0, 1, 2, 3 and 5 as analog. It clears `bus_rdata` to 0x00.
- R2: A write to address 0 (pin) or address 1 (latch) loads `bus_wdata` into the latch. `pad_out` shows the new value one clock after the write.
- R3: A write to address 2 loads the direction register. For each bit, a 0 means the pin drives (`pad_oe` bit = 1) and a 1 means the pin is an input (`pad_oe` bit = 0). `pad_oe` updates one clock after the write.
- R4: A write to address 3 loads the analog-select register. Only bits 0, 1, 2, 3 and 5 can be set; bits 4, 6 and 7 always read as 0. A read of address 3 returns this register.
- R5: A read of address 0 returns the pad level that was sampled two clock edges before the edge that accepts the read. The level passes through a two-flop synchronizer. Every bit whose analog-select bit is 1 reads as 0.
- R6: A read of address 1 returns the latch contents, whatever the pad levels are. This includes the bits of pins configured as inputs.
- R7: A read of address 2 returns the direction register.
- R8: `bus_rdata` is registered. It shows the selected source one clock after `bus_re`, and it is 0x00 in any cycle that follows a clock with no read.
- R9: When a read and a write hit the same register in the same clock, the read returns the value the register held before that write.
- R10: For a digital output pin whose pad input follows its own drive, a pin read returns the driven latch level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register address: 0 pin, 1 latch, 2 direction, 3 analog select |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data; 0 after a clock with no read |
| pad_in | input | 8 | Level sampled at each pad |
| pad_out | output | 8 | Drive value for each pad |
| pad_oe | output | 8 | Output enable per pad, 1 means drive |

## Verification
The hardest case to reach from the ports is a pin read that lands exactly when a pad level changes. The read must return the level from two edges earlier and must not leak values through pins that are marked analog. The direction register also has to vary at the same time, so that some bits loop back the driven value and others take external levels.

The bench gets there with random mixes of direction, analog-select, latch writes and external levels that change every clock, with reads issued back to back. It keeps a history of pad levels edge by edge and predicts the value of each read from that history. Directed steps cover the reset values, the writes that are masked off for pins that cannot be analog, the latch read-modify-write, and a read and write to the same register in one clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2,
    REG_ANA = 2'd3
  } gpio_reg_e;

  typedef struct packed {
    logic lat;
    logic dir;
    logic ana;
  } gpio_wr_t;

  localparam int unsigned NUM_RD_SRC = 4;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
(
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [1:0]            bus_addr,
  output gpio_wr_t              wr,
  output logic [NUM_RD_SRC-1:0] rd_sel
);

  gpio_reg_e reg_sel;
  assign reg_sel = gpio_reg_e'(bus_addr);

  always_comb begin
    wr     = '0;
    rd_sel = '0;
    if (bus_we) begin
      unique case (reg_sel)
        REG_PIN, REG_LAT: wr.lat = 1'b1;
        REG_DIR:          wr.dir = 1'b1;
        REG_ANA:          wr.ana = 1'b1;
        default:          wr     = '0;
      endcase
    end
    if (bus_re) rd_sel[bus_addr] = 1'b1;
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter logic [WIDTH-1:0] ANALOG_MASK = 8'h2F
) (
  input  logic             clk,
  input  logic             rst,
  input  gpio_wr_t         wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] ana_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr.lat) lat_q <= wdata;
      if (wr.dir) dir_q <= wdata;
    end
  end

  // Analog-select storage exists only on capable pins.
  for (genvar i = 0; i < WIDTH; i++) begin : g_ana
    if (ANALOG_MASK[i]) begin : g_cap
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)         bit_q <= 1'b1;
        else if (wr.ana) bit_q <= wdata[i];
      end
      assign ana_q[i] = bit_q;
    end else begin : g_fixed
      assign ana_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_RD_SRC-1:0] rd_sel,
  input  logic [WIDTH-1:0]      pin_val,
  input  logic [WIDTH-1:0]      lat_val,
  input  logic [WIDTH-1:0]      dir_val,
  input  logic [WIDTH-1:0]      ana_val,
  output logic [WIDTH-1:0]      rdata
);

  logic [WIDTH-1:0] src [NUM_RD_SRC];
  logic [WIDTH-1:0] merged;

  assign src[REG_PIN] = pin_val;
  assign src[REG_LAT] = lat_val;
  assign src[REG_DIR] = dir_val;
  assign src[REG_ANA] = ana_val;

  // One-hot select: AND-OR tree, no priority chain.
  always_comb begin
    merged = '0;
    for (int k = 0; k < NUM_RD_SRC; k++)
      merged |= src[k] & {WIDTH{rd_sel[k]}};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= merged;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] ANALOG_MASK = 8'h2F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  gpio_wr_t                wr;
  logic [NUM_RD_SRC-1:0]   rd_sel;
  logic [WIDTH-1:0]        lat_q, dir_q, ana_q, pin_sync, pin_digital;

  gpio_decode u_dec (
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .wr       (wr),
    .rd_sel   (rd_sel)
  );

  gpio_regs #(.WIDTH(WIDTH), .ANALOG_MASK(ANALOG_MASK)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr),
    .wdata (bus_wdata),
    .lat_q (lat_q),
    .dir_q (dir_q),
    .ana_q (ana_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  assign pin_digital = pin_sync & ~ana_q;

  gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (rd_sel),
    .pin_val (pin_digital),
    .lat_val (lat_q),
    .dir_val (dir_q),
    .ana_val (ana_q),
    .rdata   (bus_rdata)
  );

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned      WIDTH       = 8,
  parameter logic [WIDTH-1:0] ANALOG_MASK = 8'h2F
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic             bus_re,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] ana_q
);

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_addr[1]) |=> pad_out == $past(bus_wdata));

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2) |=> pad_oe == ~$past(bus_wdata));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  // R4
  ana_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 2'd3) |=> (bus_rdata & ~ANALOG_MASK) == '0);

  // R5
  pin_analog_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 2'd0) |=> (bus_rdata & $past(ana_q)) == '0);

  // R8
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ANALOG_MASK(ANALOG_MASK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .ana_q     (ana_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

  localparam logic [7:0] AMASK = 8'h2F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, pad_in, pad_out, pad_oe, ext = '0;

  int total = 0, bad = 0;
  logic [7:0] lat_m = 8'h00, dir_m = 8'hFF, ana_m = AMASK, h1 = '0, h2 = '0;

  always #2 clk = ~clk;

  assign pad_in = (pad_out & pad_oe) | (ext & ~pad_oe);

  gpio_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] read_model(logic re, logic [1:0] a);
    if (!re) return 8'h00;
    case (a)
      2'd0:    return h2 & ~ana_m;
      2'd1:    return lat_m;
      2'd2:    return dir_m;
      default: return ana_m;
    endcase
  endfunction

  function automatic string rd_tag(logic re, logic [1:0] a);
    if (!re) return "R8";
    case (a)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R4";
    endcase
  endfunction

  // One bus cycle: drive at negedge, accept at posedge, check at next negedge.
  task automatic step(logic we, logic re, logic [1:0] a, logic [7:0] wd,
                      logic [7:0] e, string tag = "");
    logic [7:0] exp_rd;
    string      t;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; ext = e;
    #1;
    exp_rd = read_model(re, a);
    h2 = h1;
    h1 = pad_in;
    if (we) begin
      case (a)
        2'd0, 2'd1: lat_m = wd;
        2'd2:       dir_m = wd;
        default:    ana_m = wd & AMASK;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    t = (tag != "") ? tag : rd_tag(re, a);
    check(t, bus_rdata, exp_rd);
    check("R2", pad_out, lat_m);
    check("R3", pad_oe, ~dir_m);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", pad_oe, 8'h00);
    check("R1", pad_out, 8'h00);
    check("R1", bus_rdata, 8'h00);
    step(0, 1, 2'd3, 8'h00, 8'h00, "R1");
    step(0, 1, 2'd2, 8'h00, 8'h00, "R1");
    // R4 masked analog-select writes
    step(1, 0, 2'd3, 8'hFF, 8'hFF);
    step(0, 1, 2'd3, 8'h00, 8'hFF, "R4");
    step(1, 0, 2'd3, 8'hD0, 8'hFF);
    step(0, 1, 2'd3, 8'h00, 8'hFF, "R4");
    // R5 analog pins read zero while pads are high
    step(1, 0, 2'd3, 8'h2F, 8'hFF);
    step(0, 0, 2'd0, 8'h00, 8'hFF);
    step(0, 1, 2'd0, 8'h00, 8'hFF, "R5");
    // R10 all digital outputs loop back driven level
    step(1, 0, 2'd3, 8'h00, 8'h00);
    step(1, 0, 2'd2, 8'h00, 8'h00);
    step(1, 0, 2'd0, 8'hA5, 8'h00);
    step(0, 0, 2'd0, 8'h00, 8'h00);
    step(0, 1, 2'd0, 8'h00, 8'h00, "R10");
    step(0, 1, 2'd0, 8'h00, 8'h00, "R10");
    // R6 latch readback keeps input-pin bits, unlike the pin path
    step(1, 0, 2'd2, 8'hF0, 8'h3C);
    step(0, 1, 2'd1, 8'h00, 8'h3C, "R6");
    step(1, 0, 2'd1, 8'hA5 | 8'h02, 8'h3C);
    step(0, 1, 2'd1, 8'h00, 8'h3C, "R6");
    // R9 read and write of same register in one clock
    step(1, 1, 2'd1, 8'h5A, 8'h00, "R9");
    step(1, 1, 2'd2, 8'h0F, 8'h00, "R9");
    step(1, 1, 2'd3, 8'h21, 8'h00, "R9");
    step(0, 1, 2'd1, 8'h00, 8'h00, "R9");
    // R5 two-edge latency on a single pad change
    step(1, 0, 2'd2, 8'hFF, 8'h00);
    step(1, 0, 2'd3, 8'h00, 8'h00);
    step(0, 0, 2'd0, 8'h00, 8'h00);
    step(0, 0, 2'd0, 8'h00, 8'h00);
    step(0, 1, 2'd0, 8'h00, 8'h81, "R5");
    step(0, 1, 2'd0, 8'h00, 8'h81, "R5");
    step(0, 1, 2'd0, 8'h00, 8'h81, "R5");
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a  = 2'($urandom_range(0, 3));
      logic       we = ($urandom_range(0, 3) == 0);
      logic       re = ($urandom_range(0, 3) != 0);
      step(we, re, a, 8'($urandom), 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule